// File: doc/BRIEF.md
# Emergency Output-Disable Input Controller

This block watches one active-low emergency input. When the chosen detection condition is seen, it latches a sticky request flag. From that flag it drives a high-impedance request to a group of output drivers and an interrupt request. Software sets each of these two outputs on or off with its own enable field. Detection is either a falling edge on the input, or a run of low samples taken with a strobe from a free-running prescaler. Software selects one of three strobe rates.

The block has one 16-bit control/status register on a plain register bus with read strobe, write strobe, address, write data and read data. Read data is combinational and valid while the read strobe is high. The flag clears only through a fixed sequence. Software first reads the register and sees the flag at 1, then writes 0 to the flag bit. In the sampled-level modes there is one more condition: the input must also have been sampled high after the flag was set. The register bus is a control path with no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `emerg_disable_ctrl`

## Requirements
- R1: After reset the register reads 0x0000, and `hiz_req` and `irq_req` are low.
- R2: The register layout is: bit 12 flag, bit 9 high-impedance enable, bit 8 interrupt enable, bits 1:0 detection mode. All other bits read 0 and ignore writes. Writing 0xFFFF while the flag is 0 reads back as 0x0303.
- R3: Writes at any address other than `REG_ADDR` (default 0) are ignored. Reads there return 0x0000.
- R4: In mode 00, a high-to-low transition of `pin_n` sets the flag. The input goes through a two-flop synchronizer and then the edge detector, so the flag becomes visible after the third rising clock edge that follows the change of the pin.
- R5: The level modes are 01 (one sample every 8 clocks), 10 (every 16 clocks) and 11 (every 128 clocks). In these modes, 16 consecutive low samples set the flag, and any high sample restarts the count.
- R6: Writing 1 to the flag bit has no effect. Writing 0 clears the flag only if a read has returned the flag as 1 since the flag was last set.
- R7: In a level mode, a clear is accepted only after a high sample has been taken since the flag was last set. A rejected clear leaves the flag at 1.
- R8: When a detection event and a valid clear fall in the same cycle, the flag stays 1. The flag must then be read again before a clear takes effect.
- R9: `hiz_req` is high exactly when both the flag and the high-impedance enable are 1.
- R10: `irq_req` is high exactly when both the flag and the interrupt enable are 1.
- R11: The flag rises only through a detection event. A software write cannot set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_n | input | 1 | Asynchronous active-low emergency input |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational while `bus_rd` is high and the address hits |
| hiz_req | output | 1 | Request to put the controlled outputs in high impedance |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions check four rules on every cycle:
- the flag rises only from a detection event;
- the flag falls only on a write that has been armed by a read;
- a level-mode clear falls only after a high sample;
- a detection event always leaves the flag at 1 in the next cycle.

The bench scenarios show the behaviours that need a timed stimulus. These are the edge latency, the 16-sample threshold at each of the three strobe rates, and a restarted low run that must not trigger. They also cover the rejected clear while the input is still low, and the exact cycle where a clear collides with a new edge. The output gating is shown across all four enable combinations.

// File: rtl/odc_pkg.sv
package odc_pkg;
  typedef enum logic [1:0] {
    DET_FALL  = 2'b00,
    DET_LOW_A = 2'b01,
    DET_LOW_B = 2'b10,
    DET_LOW_C = 2'b11
  } det_mode_e;

  localparam int REG_W    = 16;
  localparam int FLAG_BIT = 12;
  localparam int HZ_BIT   = 9;
  localparam int IE_BIT   = 8;
endpackage

// File: rtl/odc_sync.sv
module odc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= 1'b1;
        else if (s == 0) chain[s] <= din;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/odc_prescale.sv
module odc_prescale #(
  parameter int DIV_LOG_1 = 3,
  parameter int DIV_LOG_2 = 4,
  parameter int DIV_LOG_3 = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [3:0] strobe
);
  function automatic int log_of(input int idx);
    case (idx)
      1:       return DIV_LOG_1;
      2:       return DIV_LOG_2;
      default: return DIV_LOG_3;
    endcase
  endfunction

  localparam int MAX12 = (DIV_LOG_1 > DIV_LOG_2) ? DIV_LOG_1 : DIV_LOG_2;
  localparam int CNT_W = (MAX12 > DIV_LOG_3) ? MAX12 : DIV_LOG_3;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign strobe[0] = 1'b0;

  generate
    for (genvar g = 1; g < 4; g++) begin : g_strobe
      assign strobe[g] = &cnt[log_of(g)-1:0];
    end
  endgenerate
endmodule

// File: rtl/odc_detect.sv
module odc_detect
  import odc_pkg::*;
#(
  parameter int LOW_RUN = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_s,
  input  det_mode_e mode,
  input  logic      strobe_sel,
  output logic      set_evt,
  output logic      high_seen
);
  localparam int RUN_W = $clog2(LOW_RUN + 1);

  logic             prev;
  logic [RUN_W-1:0] run;
  logic             level;
  logic             fall;
  logic             low_hit;

  assign level   = (mode != DET_FALL);
  assign fall    = prev & ~pin_s;
  assign low_hit = level & strobe_sel & ~pin_s & (run == RUN_W'(LOW_RUN - 1));
  assign set_evt = level ? low_hit : fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else prev <= pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (!level) run <= '0;
    else if (strobe_sel) begin
      if (pin_s) run <= '0;
      else if (run != RUN_W'(LOW_RUN)) run <= run + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) high_seen <= 1'b0;
    else if (set_evt) high_seen <= 1'b0;
    else if (level && strobe_sel && pin_s) high_seen <= 1'b1;
  end
endmodule

// File: rtl/odc_regs.sv
module odc_regs
  import odc_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              set_evt,
  input  logic              high_seen,
  output logic [REG_W-1:0]  bus_rdata,
  output det_mode_e         mode,
  output logic              flag,
  output logic              hz_en,
  output logic              irq_en
);
  logic hit, rd_hit, wr_hit, armed, clear_ok;
  logic unused_wdata;

  assign hit      = (bus_addr == ADDR_W'(REG_ADDR));
  assign rd_hit   = bus_rd & hit;
  assign wr_hit   = bus_wr & hit;
  assign clear_ok = wr_hit & ~bus_wdata[FLAG_BIT] & armed & flag &
                    ((mode == DET_FALL) | high_seen);
  assign unused_wdata = ^{bus_wdata[15:13], bus_wdata[11:10], bus_wdata[7:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hz_en  <= 1'b0;
      irq_en <= 1'b0;
      mode   <= DET_FALL;
    end else if (wr_hit) begin
      hz_en  <= bus_wdata[HZ_BIT];
      irq_en <= bus_wdata[IE_BIT];
      mode   <= det_mode_e'(bus_wdata[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clear_ok) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (set_evt || clear_ok) armed <= 1'b0;
    else if (rd_hit && flag) armed <= 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      bus_rdata[FLAG_BIT] = flag;
      bus_rdata[HZ_BIT]   = hz_en;
      bus_rdata[IE_BIT]   = irq_en;
      bus_rdata[1:0]      = mode;
    end
  end

  assert_set_from_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set_evt));
  assert_clear_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed && wr_hit && !bus_wdata[FLAG_BIT]));
  assert_level_clear_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flag) && $past(mode) != DET_FALL) |-> $past(high_seen));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_evt) |-> flag);
endmodule

// File: rtl/emerg_disable_ctrl.sv
module emerg_disable_ctrl
  import odc_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int REG_ADDR    = 0,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LOG_1   = 3,
  parameter int DIV_LOG_2   = 4,
  parameter int DIV_LOG_3   = 7,
  parameter int LOW_RUN     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              hiz_req,
  output logic              irq_req
);
  logic      pin_s;
  logic [3:0] strobe;
  det_mode_e mode;
  logic      set_evt, high_seen, flag, hz_en, irq_en;

  odc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_n), .dout(pin_s)
  );

  odc_prescale #(
    .DIV_LOG_1(DIV_LOG_1), .DIV_LOG_2(DIV_LOG_2), .DIV_LOG_3(DIV_LOG_3)
  ) u_presc (
    .clk(clk), .rst_n(rst_n), .strobe(strobe)
  );

  odc_detect #(.LOW_RUN(LOW_RUN)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .mode(mode),
    .strobe_sel(strobe[mode]), .set_evt(set_evt), .high_seen(high_seen)
  );

  odc_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .set_evt(set_evt),
    .high_seen(high_seen), .bus_rdata(bus_rdata), .mode(mode),
    .flag(flag), .hz_en(hz_en), .irq_en(irq_en)
  );

  assign hiz_req = flag & hz_en;
  assign irq_req = flag & irq_en;
endmodule

// File: tb/emerg_disable_ctrl_bench.sv
module emerg_disable_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_n = 1'b1;
  logic bus_rd = 1'b0;
  logic bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic hiz_req, irq_req;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  emerg_disable_ctrl u_emerg_disable_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hiz_req(hiz_req), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic do_rd(input logic [ADDR_W-1:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [15:0] ctrl;
    int d;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    chk("R1 hiz", {15'd0, hiz_req}, 16'h0);
    chk("R1 irq", {15'd0, irq_req}, 16'h0);
    do_rd(0, v); chk("R1 reg", v, 16'h0000);

    // R2 layout and reserved bits
    do_wr(0, 16'hFFFF); do_rd(0, v); chk("R2 readback", v, 16'h0303);
    do_wr(0, 16'h0000); do_rd(0, v); chk("R2 cleared", v, 16'h0000);

    // R3 other address
    do_wr(0, 16'h0100);
    do_wr(1, 16'hFFFF); do_rd(0, v); chk("R3 write ignored", v, 16'h0100);
    do_rd(1, v); chk("R3 read zero", v, 16'h0000);

    // R11 software cannot set flag
    do_wr(0, 16'h1100); wait_cyc(2);
    chk("R11 irq", {15'd0, irq_req}, 16'h0);
    do_rd(0, v); chk("R11 reg", v, 16'h0100);

    // R4, R9, R10: edge mode over all enable combinations
    for (int e = 0; e < 4; e++) begin
      ctrl = 16'((e & 2) << 8) | 16'((e & 1) << 8);
      do_wr(0, ctrl);
      wait_cyc(3);
      @(negedge clk); pin_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R4 not yet after two edges", {14'd0, hiz_req, irq_req}, 16'h0);
      @(negedge clk);
      chk("R9 hiz", {15'd0, hiz_req}, 16'((e >> 1) & 1));
      chk("R10 irq", {15'd0, irq_req}, 16'(e & 1));
      do_rd(0, v); chk("R4 flag read", v, 16'h1000 | ctrl);
      pin_n = 1'b1;
      do_wr(0, ctrl); wait_cyc(1);
      chk("R6 cleared outputs", {14'd0, hiz_req, irq_req}, 16'h0);
      do_rd(0, v); chk("R6 cleared reg", v, ctrl);
    end

    // R6 read-then-write-0 rule
    do_wr(0, 16'h0100); wait_cyc(3);
    @(negedge clk); pin_n = 1'b0; wait_cyc(4); pin_n = 1'b1;
    do_wr(0, 16'h0100); wait_cyc(1);
    chk("R6 no clear without read", {15'd0, irq_req}, 16'h1);
    do_rd(0, v);
    do_wr(0, 16'h1100); wait_cyc(1);
    chk("R6 write 1 no effect", {15'd0, irq_req}, 16'h1);
    do_wr(0, 16'h0100); wait_cyc(1);
    chk("R6 clear after read", {15'd0, irq_req}, 16'h0);

    // R8 set wins over simultaneous clear
    @(negedge clk); pin_n = 1'b0; wait_cyc(4); pin_n = 1'b1; wait_cyc(4);
    do_rd(0, v); chk("R8 flag set", v, 16'h1100);
    @(negedge clk); pin_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = '0; bus_wdata = 16'h0100;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    chk("R8 flag kept", {15'd0, irq_req}, 16'h1);
    pin_n = 1'b1; wait_cyc(4);
    do_wr(0, 16'h0100); wait_cyc(1);
    chk("R8 needs new read", {15'd0, irq_req}, 16'h1);
    do_rd(0, v); do_wr(0, 16'h0100); wait_cyc(1);
    chk("R8 clear after reread", {15'd0, irq_req}, 16'h0);

    // R5, R7: level modes
    for (int m = 1; m < 4; m++) begin
      d = (m == 1) ? 8 : (m == 2) ? 16 : 128;
      ctrl = 16'h0300 | 16'(m);
      pin_n = 1'b1;
      do_wr(0, ctrl);
      wait_cyc(2*d + 4);
      pin_n = 1'b0;
      wait_cyc(14*d);
      chk("R5 below threshold", {15'd0, irq_req}, 16'h0);
      wait_cyc(4*d + 4);
      chk("R5 threshold irq", {15'd0, irq_req}, 16'h1);
      chk("R9 level hiz", {15'd0, hiz_req}, 16'h1);
      do_rd(0, v); chk("R5 flag read", v, 16'h1000 | ctrl);
      do_wr(0, ctrl);
      do_rd(0, v); chk("R7 clear rejected while low", v, 16'h1000 | ctrl);
      pin_n = 1'b1;
      wait_cyc(2*d + 4);
      do_rd(0, v);
      do_wr(0, ctrl); wait_cyc(1);
      chk("R7 clear after high sample", {15'd0, irq_req}, 16'h0);
      pin_n = 1'b0; wait_cyc(10*d);
      pin_n = 1'b1; wait_cyc(2*d + 4);
      pin_n = 1'b0; wait_cyc(10*d);
      chk("R5 high sample restarts run", {15'd0, irq_req}, 16'h0);
      pin_n = 1'b1; wait_cyc(2*d + 4);
    end

    finish_run();
  end
endmodule